// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of a two-wire serial memory. A master on the shared clock and data lines selects it with a control byte that carries a 7-bit device address and a direction bit. A write sends a two-byte word address and then data bytes. Those bytes are held in a small pending buffer. The stop that closes the write starts a timed internal update, and only when that update finishes do the bytes reach the byte array. While the update runs the slave refuses its own control byte, so a master can poll with bare control bytes until it gets an acknowledge.

One address counter serves both reads and writes. It always points one past the byte last touched. A read control byte on its own returns the byte at the counter. To read from any location, the master sends the word address in write mode, breaks off with a repeated start, and then sends a read control byte. If the master acknowledges a read byte, the next byte follows. The data line is driven only low, through an enable output, and both bus lines pass through two-flop synchronisers before start and stop are decoded.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the data-line enable is low, the address counter is 0 and no update is running, so a first control byte with the device address is acknowledged.
- R2: A control byte whose upper seven bits equal DEV_ADDR (default 7'h50; bit 0 is 1 for read, 0 for write) is acknowledged by pulling the data line low in the ninth clock. Any other address is not acknowledged, and the slave leaves the data line alone until the next start.
- R3: In a write, the slave acknowledges the control byte, an address high byte, an address low byte and each data byte. Data byte k lands at word address plus k once the update completes.
- R4: The stop after a write that carried at least one data byte starts an update of WR_CYCLES clocks. During it the slave drives nothing and refuses its control byte. Afterwards it acknowledges again.
- R5: A write that sends only the word address and then a stop starts no update, and the next control byte is acknowledged at once.
- R6: A read control byte with no word address returns the byte at the counter, and the counter then equals the read address plus one.
- R7: After a word address sent in write mode, a repeated start and a read control byte are acknowledged, and the slave returns the byte at that address.
- R8: A master acknowledge on a read byte makes the slave send the byte at the next address. Addresses for reads and writes wrap from 4095 to 0.
- R9: A repeated start that ends a write after its data bytes discards those bytes. The array keeps its old contents, no update starts, and the counter stays one past the last data byte sent.
- R10: The pending buffer holds BUF_DEPTH bytes (default 16). A data byte beyond that is not acknowledged and is neither stored nor counted.
- R11: Only the low AW-8 bits (default 4) of the address high byte are used, so word addresses are 12 bits wide.
- R12: A start or a stop releases the data line within the synchroniser delay, whatever the slave was doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pulls the data line low when 1 |

## Verification
The bench writes the top byte of the array and the first byte in one write, then reads them back across the boundary. A counter or commit index that failed to wrap would return or corrupt the wrong byte. It polls right after each stop and expects a refusal first and an acknowledge later: a slave that ignored its busy state would answer at once, and one that never finished the update would time out the poll. Address-only writes, writes aborted by a repeated start, and a write one byte longer than the buffer each catch a slave that starts a needless update, commits dropped bytes or miscounts the pointer. Foreign addresses and a high byte with junk upper bits catch a loose address match or decode.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_HOLD,
        ST_ACK_OUT,
        ST_TX,
        ST_ACK_IN
    } link_state_e;

    typedef enum logic [1:0] {
        PH_CTRL,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic ctrl_match(logic [7:0] b, logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import eeprom_i2c_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic scl_m, scl_s, scl_d;
    logic sda_m, sda_s, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
            sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
        end else begin
            scl_m <= scl_in; scl_s <= scl_m; scl_d <= scl_s;
            sda_m <= sda_in; sda_s <= sda_m; sda_d <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= CW'(CYCLES);
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign busy = cnt != '0;
    assign done = cnt == CW'(1);
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW        = 12,
    parameter int BUF_DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base_addr,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          drop,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          full,
    output logic          has_data
);
    localparam int DEPTH = 1 << AW;
    localparam int NW    = $clog2(BUF_DEPTH + 1);

    logic [7:0]             mem [DEPTH];
    logic [AW-1:0]          base_q;
    logic [NW-1:0]          pend_n;
    logic [BUF_DEPTH*8-1:0] pflat;

    genvar g;
    generate
        for (g = 0; g < BUF_DEPTH; g++) begin : g_ent
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (push && !full && pend_n == NW'(g)) q <= push_data;
            end
            assign pflat[g*8 +: 8] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            pend_n <= '0;
        end else if (load) begin
            base_q <= base_addr;
            pend_n <= '0;
        end else if (push && !full) begin
            pend_n <= pend_n + NW'(1);
        end else if (drop || commit) begin
            pend_n <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < BUF_DEPTH; i++) begin
                if (NW'(i) < pend_n) mem[AW'(base_q + AW'(i))] <= pflat[i*8 +: 8];
            end
        end
    end

    assign rd_data  = mem[rd_addr];
    assign full     = pend_n == NW'(BUF_DEPTH);
    assign has_data = pend_n != '0;
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         AW        = 12,
    parameter int         BUF_DEPTH = 16,
    parameter int         WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    localparam int HW = AW - 8;

    bus_ev_t       bus_ev;
    link_state_e   state;
    rx_phase_e     phase;
    logic [2:0]    bit_cnt;
    logic [7:0]    shreg, tx_sh, rx_byte, rd_data;
    logic [HW-1:0] hi_q;
    logic [AW-1:0] addr_cnt;
    logic          rd_mode, ack_pend, mst_ack, wr_active, sda_oe_q;
    logic          wr_busy, wr_done, buf_full, buf_has;
    logic          byte_done, s_load, s_push, s_drop, tmr_start;
    logic          ev_start, ev_stop, ev_fall;

    i2c_line_sync u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(bus_ev)
    );

    eeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(tmr_start), .busy(wr_busy), .done(wr_done)
    );

    eeprom_store #(.AW(AW), .BUF_DEPTH(BUF_DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .load(s_load), .base_addr({hi_q, rx_byte}),
        .push(s_push), .push_data(rx_byte),
        .drop(s_drop), .commit(wr_done),
        .rd_addr(addr_cnt), .rd_data(rd_data),
        .full(buf_full), .has_data(buf_has)
    );

    assign ev_start = bus_ev.start;
    assign ev_stop  = bus_ev.stop;
    assign ev_fall  = bus_ev.scl_fall;

    always_comb begin
        rx_byte   = {shreg[6:0], bus_ev.sda};
        byte_done = (state == ST_RX) && bus_ev.scl_rise && (bit_cnt == 3'd7);
        s_load    = byte_done && (phase == PH_ADDR_LO);
        s_push    = byte_done && (phase == PH_DATA) && !buf_full;
        s_drop    = bus_ev.start && wr_active;
        tmr_start = bus_ev.stop && wr_active && buf_has;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_CTRL;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_sh     <= '0;
            hi_q      <= '0;
            addr_cnt  <= '0;
            rd_mode   <= 1'b0;
            ack_pend  <= 1'b0;
            mst_ack   <= 1'b0;
            wr_active <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else if (bus_ev.start) begin
            state     <= ST_RX;
            phase     <= PH_CTRL;
            bit_cnt   <= '0;
            wr_active <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else if (bus_ev.stop) begin
            state     <= ST_IDLE;
            wr_active <= 1'b0;
            sda_oe_q  <= 1'b0;
        end else begin
            case (state)
                ST_RX: if (bus_ev.scl_rise) begin
                    shreg   <= rx_byte;
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        state <= ST_HOLD;
                        case (phase)
                            PH_CTRL: begin
                                ack_pend <= ctrl_match(rx_byte, DEV_ADDR) && !wr_busy;
                                rd_mode  <= rx_byte[0];
                                phase    <= rx_byte[0] ? PH_CTRL : PH_ADDR_HI;
                            end
                            PH_ADDR_HI: begin
                                hi_q     <= rx_byte[HW-1:0];
                                ack_pend <= 1'b1;
                                phase    <= PH_ADDR_LO;
                            end
                            PH_ADDR_LO: begin
                                addr_cnt  <= {hi_q, rx_byte};
                                wr_active <= 1'b1;
                                ack_pend  <= 1'b1;
                                phase     <= PH_DATA;
                            end
                            default: begin
                                ack_pend <= !buf_full;
                                if (!buf_full) addr_cnt <= addr_cnt + AW'(1);
                            end
                        endcase
                    end
                end
                ST_HOLD: if (bus_ev.scl_fall) begin
                    sda_oe_q <= ack_pend;
                    state    <= ack_pend ? ST_ACK_OUT : ST_IDLE;
                end
                ST_ACK_OUT: if (bus_ev.scl_fall) begin
                    bit_cnt <= '0;
                    if (rd_mode) begin
                        tx_sh    <= rd_data;
                        addr_cnt <= addr_cnt + AW'(1);
                        sda_oe_q <= ~rd_data[7];
                        state    <= ST_TX;
                    end else begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_RX;
                    end
                end
                ST_TX: if (bus_ev.scl_fall) begin
                    if (bit_cnt == 3'd7) begin
                        sda_oe_q <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_ACK_IN;
                    end else begin
                        tx_sh    <= {tx_sh[6:0], 1'b0};
                        sda_oe_q <= ~tx_sh[6];
                        bit_cnt  <= bit_cnt + 3'd1;
                    end
                end
                ST_ACK_IN: begin
                    if (bus_ev.scl_rise) mst_ack <= ~bus_ev.sda;
                    if (bus_ev.scl_fall) begin
                        if (mst_ack) begin
                            tx_sh    <= rd_data;
                            addr_cnt <= addr_cnt + AW'(1);
                            sda_oe_q <= ~rd_data[7];
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic busy,
    input logic start_ev,
    input logic stop_ev,
    input logic fall_ev,
    input logic tmr_start
);
    AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe); // R4

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_ev)); // R4

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        tmr_start |-> !busy); // R4

    AST_RELEASE_ON_COND: assert property (@(posedge clk) disable iff (rst)
        (start_ev || stop_ev) |=> !sda_oe); // R12

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> $past(fall_ev || start_ev || stop_ev)); // R2
endmodule

bind eeprom_i2c_slave eeprom_i2c_checker u_chk (
    .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(wr_busy),
    .start_ev(ev_start), .stop_ev(ev_stop), .fall_ev(ev_fall),
    .tmr_start(tmr_start)
);

// File: tb/tb_eeprom_i2c_slave.sv
module tb_eeprom_i2c_slave;
    localparam int WRC = 300;
    localparam int Q   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    eeprom_i2c_slave #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] model [4096];
    bit         valid [4096];
    int         mcnt = 0;
    logic [7:0] wdat [20];
    bit mon_en = 0;
    bit mon_hit = 0;

    always @(posedge clk) if (mon_en && sda_oe) mon_hit = 1;

    task automatic wq(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int wrapa(int a);
        return a & 12'hFFF;
    endfunction

    task automatic bus_start();
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
        end
        sda_m = 1; wq(Q); scl_m = 1; wq(Q);
        ack = !sda_line;
        wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 0;
        end
        wq(Q); sda_m = !mack; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
        sda_m = 1;
    endtask

    task automatic poll_ready(output int polls);
        bit a;
        polls = 0;
        for (int k = 0; k < 50; k++) begin
            bus_start(); write_byte(8'hA0, a); bus_stop();
            if (a) break;
            polls++;
        end
    endtask

    // write with raw high/low address bytes, n bytes from wdat
    task automatic write_raw(input logic [7:0] hi, input logic [7:0] lo, input int n);
        bit a; bit all_ok; int polls; int base;
        all_ok = 1;
        base = {hi[3:0], lo};
        bus_start();
        write_byte(8'hA0, a); all_ok &= a;
        write_byte(hi, a); all_ok &= a;
        write_byte(lo, a); all_ok &= a;
        for (int i = 0; i < n; i++) begin write_byte(wdat[i], a); all_ok &= a; end
        bus_stop();
        chk("R3", "write bytes acknowledged", int'(all_ok), 1);
        for (int i = 0; i < n; i++) begin
            model[wrapa(base + i)] = wdat[i]; valid[wrapa(base + i)] = 1;
        end
        mcnt = wrapa(base + n);
        bus_start(); write_byte(8'hA0, a); bus_stop();
        chk("R4", "control refused right after stop", int'(a), 0);
        poll_ready(polls);
        chk("R4", "ready within poll limit", int'(polls < 49), 1);
    endtask

    task automatic write_txn(input int addr, input int n);
        write_raw(8'(addr >> 8), 8'(addr), n);
    endtask

    task automatic read_seq(input int n, input int first, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            read_byte(i < n - 1, b);
            if (valid[wrapa(first + i)])
                chk(req, $sformatf("read @%0h", wrapa(first + i)), b, model[wrapa(first + i)]);
        end
        bus_stop();
        mcnt = wrapa(first + n);
        chk("R12", "data line free after stop", int'(sda_oe), 0);
    endtask

    task automatic rand_read(input int addr, input int n, input string req);
        bit a0, a1, a2, a3;
        bus_start();
        write_byte(8'hA0, a0);
        write_byte(8'(addr >> 8), a1);
        write_byte(8'(addr), a2);
        bus_start();
        write_byte(8'hA1, a3);
        chk("R7", "random read acks", int'(a0 & a1 & a2 & a3), 1);
        read_seq(n, addr, req);
    endtask

    task automatic cur_read(input int n, input string req);
        bit a;
        bus_start();
        write_byte(8'hA1, a);
        chk(req, "current read ack", int'(a), 1);
        read_seq(n, mcnt, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4096; i++) begin model[i] = 8'h00; valid[i] = 0; end
        wq(5);
        rst = 0;
        wq(5);
        chk("R1", "enable low after reset", int'(sda_oe), 0);
        bus_start(); write_byte(8'hA0, a); bus_stop();
        chk("R1", "first control acknowledged", int'(a), 1);

        // R2: foreign address
        mon_hit = 0; mon_en = 1;
        bus_start(); write_byte(8'hA2, a);
        chk("R2", "foreign address not acked", int'(a), 0);
        write_byte(8'h00, a);
        chk("R2", "following byte not acked", int'(a), 0);
        bus_stop();
        mon_en = 0;
        chk("R2", "line never driven", int'(mon_hit), 0);

        // R3 / R8 directed write and sequential read
        wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
        write_txn(12'h123, 3);
        rand_read(12'h123, 3, "R8");

        // R5 address-only write, then current reads (R6)
        bus_start(); write_byte(8'hA0, a); write_byte(8'h01, a); write_byte(8'h24, a); bus_stop();
        mcnt = 12'h124;
        bus_start(); write_byte(8'hA0, a); bus_stop();
        chk("R5", "no update after address-only write", int'(a), 1);
        cur_read(1, "R6");
        cur_read(1, "R6");

        // R8 wrap at the top address
        wdat[0] = 8'hA5; wdat[1] = 8'h5A;
        write_txn(12'hFFF, 2);
        rand_read(12'hFFF, 2, "R8");
        cur_read(1, "R6");

        // R11 high byte junk bits
        wdat[0] = 8'hC3;
        write_raw(8'hF3, 8'h21, 1);
        rand_read(12'h321, 1, "R11");

        // R9 write aborted by repeated start
        wdat[0] = 8'h40; wdat[1] = 8'h41;
        write_txn(12'h200, 2);
        bus_start(); write_byte(8'hA0, a); write_byte(8'h02, a); write_byte(8'h00, a);
        write_byte(8'hEE, a);
        bus_start(); write_byte(8'hA1, a);
        chk("R9", "read control acked after abort", int'(a), 1);
        read_byte(0, b); bus_stop();
        chk("R9", "counter one past aborted byte", b, model[12'h201]);
        rand_read(12'h200, 1, "R9");

        // R10 buffer overflow
        wdat[0] = 8'h77;
        write_txn(12'h410, 1);
        bus_start(); write_byte(8'hA0, a); write_byte(8'h04, a); write_byte(8'h00, a);
        for (int i = 0; i < 16; i++) begin
            write_byte(8'(8'h80 + i), a);
            model[12'h400 + i] = 8'(8'h80 + i); valid[12'h400 + i] = 1;
        end
        write_byte(8'hFF, a);
        chk("R10", "byte beyond buffer refused", int'(a), 0);
        bus_stop();
        begin int p; poll_ready(p); chk("R10", "ready after overflow write", int'(p < 49), 1); end
        mcnt = 12'h410;
        cur_read(1, "R10");
        rand_read(12'h400, 16, "R10");

        // random writes and read-backs
        for (int it = 0; it < 12; it++) begin
            int ad; int n;
            ad = int'($urandom % 4096);
            n  = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wdat[i] = 8'($urandom);
            write_txn(ad, n);
            rand_read(ad, n, "R3");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule